// File: doc/BRIEF.md
# Receive Link Polarity Detector

This block decides whether the receive pair of a twisted-pair port is wired with reversed polarity. It watches the link-pulse events that an upstream pulse detector has already qualified. These are normal link pulses seen upright or inverted, and the clock pulses inside a fast-link-pulse burst seen upright or inverted, with a strobe that marks the end of each burst. Detection runs only while the port is in auto-negotiation or 10 Mb/s operation, which `det_en_i` signals.

In automatic mode, either of two conditions marks the pair as reversed. One is a run of eight inverted normal link pulses with no upright pulse between them. The other is a single burst whose clock pulses were all inverted. The reverse-polarity bit is then set and held, and the receive data is inverted. Only a link failure or a reset clears it, so the decision does not toggle back and forth. Setting the auto-polarity disable input hands control to software. The bit then becomes a plain writable force bit and detection is ignored.

Top module: `rx_polarity_det`

## Requirements
- R1: After reset `rev_pol_o` and `rx_invert_o` are both 0.
- R2: In automatic mode (`auto_pol_off_i`=0) with `det_en_i`=1, the eighth consecutive inverted normal link pulse sets `rev_pol_o` to 1 at the clock edge that samples it. Seven such pulses leave it at 0.
- R3: An upright normal link pulse resets the inverted-pulse run to zero, so eight further inverted pulses are needed after it.
- R4: In automatic mode, a burst that ends (`flp_end_i`) after at least one inverted clock pulse and no upright clock pulse sets `rev_pol_o` at that edge. A burst containing any upright clock pulse does not set it.
- R5: Once set in automatic mode, `rev_pol_o` stays 1 through upright pulses and upright bursts until `link_fail_i` is sampled high, which clears it at that edge. A clear wins over a detection in the same cycle.
- R6: In automatic mode a write (`pol_wr_i`=1) has no effect on `rev_pol_o`.
- R7: In manual mode (`auto_pol_off_i`=1) a write loads `pol_wdata_i` into `rev_pol_o` at the next edge. Pulse events and `link_fail_i` have no effect in this mode.
- R8: While `det_en_i`=0, pulse and burst events set nothing and clear any partial inverted-pulse run or burst record.
- R9: `rx_invert_o` equals `rev_pol_o` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_en_i | input | 1 | High during auto-negotiation or 10 Mb/s operation |
| nlp_up_i | input | 1 | One-cycle strobe: upright normal link pulse |
| nlp_inv_i | input | 1 | One-cycle strobe: inverted normal link pulse |
| flp_up_i | input | 1 | One-cycle strobe: upright burst clock pulse |
| flp_inv_i | input | 1 | One-cycle strobe: inverted burst clock pulse |
| flp_end_i | input | 1 | One-cycle strobe: current burst has ended |
| link_fail_i | input | 1 | Link failure; clears a latched detection |
| auto_pol_off_i | input | 1 | 1 disables automatic correction (manual mode) |
| pol_wr_i | input | 1 | Write strobe for the reverse-polarity bit |
| pol_wdata_i | input | 1 | Value written to the reverse-polarity bit |
| rev_pol_o | output | 1 | Reverse-polarity status / force bit |
| rx_invert_o | output | 1 | Invert receive data |

## Verification
Runs of seven and of eight inverted normal link pulses show whether the count stops at exactly the threshold. A run broken by one upright pulse shows that the count restarts and does not merely pause. All-inverted bursts and mixed bursts show that the burst criterion needs every clock pulse inverted. Writes, link failures and events are applied in both modes and with detection disabled, which separates the latched status behaviour from the force-bit behaviour and from the gating by the enable.

// File: rtl/rx_polarity_pkg.sv
package rx_polarity_pkg;
  typedef enum logic {
    POL_AUTO   = 1'b0,
    POL_MANUAL = 1'b1
  } pol_mode_e;

  localparam int unsigned NLP_RUN_DEFAULT = 8;
endpackage

// File: rtl/rpd_nlp_run.sv
module rpd_nlp_run #(
  parameter int unsigned RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic up_i,
  input  logic inv_i,
  output logic hit_o
);
  localparam int unsigned CW = (RUN_LEN > 1) ? $clog2(RUN_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign hit_o   = en_i & inv_i & ~up_i & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || up_i)      cnt_d = '0;
    else if (inv_i) begin
      if (at_last)          cnt_d = '0;
      else                  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  // R3
  up_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && up_i) |=> (cnt_q == '0));
  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (cnt_q == '0));
endmodule

// File: rtl/rpd_flp_judge.sv
module rpd_flp_judge (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic up_i,
  input  logic inv_i,
  input  logic end_i,
  output logic hit_o
);
  logic seen_inv_q, seen_inv_d;
  logic seen_up_q,  seen_up_d;
  logic any_inv, any_up;

  assign any_inv = seen_inv_q | inv_i;
  assign any_up  = seen_up_q  | up_i;
  assign hit_o   = en_i & end_i & any_inv & ~any_up;

  always_comb begin
    seen_inv_d = seen_inv_q;
    seen_up_d  = seen_up_q;
    if (!en_i || end_i) begin
      seen_inv_d = 1'b0;
      seen_up_d  = 1'b0;
    end else begin
      if (inv_i) seen_inv_d = 1'b1;
      if (up_i)  seen_up_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_inv_q <= 1'b0;
      seen_up_q  <= 1'b0;
    end else begin
      seen_inv_q <= seen_inv_d;
      seen_up_q  <= seen_up_d;
    end
  end

  // R4
  mixed_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_up_q && end_i) |-> !hit_o);
  // R4
  burst_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_i |=> (!seen_inv_q && !seen_up_q));
endmodule

// File: rtl/rpd_pol_reg.sv
module rpd_pol_reg
  import rx_polarity_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pol_mode_e mode_i,
  input  logic      det_hit_i,
  input  logic      link_fail_i,
  input  logic      wr_i,
  input  logic      wdata_i,
  output logic      pol_o
);
  logic pol_q, pol_d;

  always_comb begin
    pol_d = pol_q;
    if (mode_i == POL_MANUAL) begin
      if (wr_i) pol_d = wdata_i;
    end else begin
      if (link_fail_i)    pol_d = 1'b0;
      else if (det_hit_i) pol_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= 1'b0;
    else        pol_q <= pol_d;
  end

  assign pol_o = pol_q;

  // R6
  auto_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == POL_AUTO && wr_i && !det_hit_i && !link_fail_i) |=> $stable(pol_o));
  // R7
  manual_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == POL_MANUAL && wr_i) |=> (pol_o == $past(wdata_i)));
  // R5
  fail_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == POL_AUTO && link_fail_i) |=> !pol_o);
  // R2
  hit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == POL_AUTO && det_hit_i && !link_fail_i) |=> pol_o);
endmodule

// File: rtl/rx_polarity_det.sv
module rx_polarity_det
  import rx_polarity_pkg::*;
#(
  parameter int unsigned NLP_RUN = NLP_RUN_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_en_i,
  input  logic nlp_up_i,
  input  logic nlp_inv_i,
  input  logic flp_up_i,
  input  logic flp_inv_i,
  input  logic flp_end_i,
  input  logic link_fail_i,
  input  logic auto_pol_off_i,
  input  logic pol_wr_i,
  input  logic pol_wdata_i,
  output logic rev_pol_o,
  output logic rx_invert_o
);
  pol_mode_e mode;
  logic      judge_en;
  logic      nlp_hit, flp_hit;

  assign mode     = auto_pol_off_i ? POL_MANUAL : POL_AUTO;
  assign judge_en = det_en_i & ~auto_pol_off_i;

  rpd_nlp_run #(.RUN_LEN(NLP_RUN)) u_nlp (
    .clk(clk), .rst_n(rst_n), .en_i(judge_en),
    .up_i(nlp_up_i), .inv_i(nlp_inv_i), .hit_o(nlp_hit)
  );

  rpd_flp_judge u_flp (
    .clk(clk), .rst_n(rst_n), .en_i(judge_en),
    .up_i(flp_up_i), .inv_i(flp_inv_i), .end_i(flp_end_i), .hit_o(flp_hit)
  );

  rpd_pol_reg u_pol (
    .clk(clk), .rst_n(rst_n), .mode_i(mode),
    .det_hit_i(nlp_hit | flp_hit), .link_fail_i(link_fail_i),
    .wr_i(pol_wr_i), .wdata_i(pol_wdata_i), .pol_o(rev_pol_o)
  );

  assign rx_invert_o = rev_pol_o;

  // R8
  gated_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en_i && !auto_pol_off_i && !rev_pol_o) |=> !rev_pol_o);
endmodule

// File: tb/rx_polarity_det_tb.sv
module rx_polarity_det_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic det_en_i, nlp_up_i, nlp_inv_i, flp_up_i, flp_inv_i, flp_end_i;
  logic link_fail_i, auto_pol_off_i, pol_wr_i, pol_wdata_i;
  logic rev_pol_o, rx_invert_o;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  rx_polarity_det u_dut (
    .clk(clk), .rst_n(rst_n), .det_en_i(det_en_i),
    .nlp_up_i(nlp_up_i), .nlp_inv_i(nlp_inv_i),
    .flp_up_i(flp_up_i), .flp_inv_i(flp_inv_i), .flp_end_i(flp_end_i),
    .link_fail_i(link_fail_i), .auto_pol_off_i(auto_pol_off_i),
    .pol_wr_i(pol_wr_i), .pol_wdata_i(pol_wdata_i),
    .rev_pol_o(rev_pol_o), .rx_invert_o(rx_invert_o)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (rev_pol_o !== exp || rx_invert_o !== exp) begin
      fails++;
      $display("FAIL %s: rev_pol=%b invert=%b expected %b", req, rev_pol_o, rx_invert_o, exp);
    end
  endtask

  // drive one strobe for one cycle; result visible at the closing negedge
  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: nlp_up_i = 1'b1;
      1: nlp_inv_i = 1'b1;
      2: flp_up_i = 1'b1;
      3: flp_inv_i = 1'b1;
      4: flp_end_i = 1'b1;
      5: link_fail_i = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    {nlp_up_i, nlp_inv_i, flp_up_i, flp_inv_i, flp_end_i, link_fail_i} = '0;
  endtask

  task automatic write(input logic v);
    @(negedge clk);
    pol_wr_i = 1'b1; pol_wdata_i = v;
    @(negedge clk);
    pol_wr_i = 1'b0; pol_wdata_i = 1'b0;
  endtask

  task automatic clear_state();
    auto_pol_off_i = 1'b0;
    det_en_i = 1'b1;
    strobe(5);
  endtask

  task automatic t_reset();
    check(1'b0, "R1");
  endtask

  task automatic t_nlp_run();
    clear_state();
    for (int i = 0; i < 7; i++) strobe(1);
    check(1'b0, "R2 seven inverted");
    strobe(1);
    check(1'b1, "R2 eighth inverted");
    check(rev_pol_o, "R9");
  endtask

  task automatic t_upright_restart();
    clear_state();
    for (int i = 0; i < 5; i++) strobe(1);
    strobe(0);
    for (int i = 0; i < 7; i++) strobe(1);
    check(1'b0, "R3 run restarted");
    strobe(1);
    check(1'b1, "R3 eighth after restart");
  endtask

  task automatic t_burst();
    clear_state();
    strobe(3); strobe(2); strobe(3); strobe(4);
    check(1'b0, "R4 mixed burst");
    strobe(3); strobe(3); strobe(4);
    check(1'b1, "R4 inverted burst");
  endtask

  task automatic t_latch();
    clear_state();
    strobe(3); strobe(4);
    strobe(0); strobe(0); strobe(2); strobe(4);
    check(1'b1, "R5 latched");
    strobe(5);
    check(1'b0, "R5 link fail clears");
  endtask

  task automatic t_auto_write();
    clear_state();
    write(1'b1);
    check(1'b0, "R6 write 1 ignored");
    strobe(3); strobe(4);
    write(1'b0);
    check(1'b1, "R6 write 0 ignored");
  endtask

  task automatic t_manual();
    clear_state();
    auto_pol_off_i = 1'b1;
    write(1'b1);
    check(1'b1, "R7 force 1");
    strobe(5);
    check(1'b1, "R7 link fail ignored");
    write(1'b0);
    check(1'b0, "R7 force 0");
    for (int i = 0; i < 8; i++) strobe(1);
    strobe(3); strobe(4);
    check(1'b0, "R7 events ignored");
    auto_pol_off_i = 1'b0;
  endtask

  task automatic t_disabled();
    clear_state();
    det_en_i = 1'b0;
    for (int i = 0; i < 8; i++) strobe(1);
    strobe(3); strobe(4);
    check(1'b0, "R8 gated events");
    for (int i = 0; i < 4; i++) strobe(1);
    det_en_i = 1'b1;
    for (int i = 0; i < 7; i++) strobe(1);
    check(1'b0, "R8 partial run cleared");
  endtask

  initial begin
    rst_n = 1'b0;
    {det_en_i, nlp_up_i, nlp_inv_i, flp_up_i, flp_inv_i, flp_end_i} = '0;
    {link_fail_i, auto_pol_off_i, pol_wr_i, pol_wdata_i} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nlp_run();
    t_upright_restart();
    t_burst();
    t_latch();
    t_auto_write();
    t_manual();
    t_disabled();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule